// File: doc/BRIEF.md
# Dual-Clock Set/Clear Flag

This block holds a single status bit that one clock domain raises and a second, unrelated clock domain lowers, with no clock shared between them. The bit is not kept in one register with set and reset inputs. It is kept in a pair of flip-flops joined in a twisted ring, one flop in each domain, and the bit is the XOR of their two outputs. A raise makes the raising flop differ from the lowering flop. A lower makes the lowering flop match the raising flop again. Each flop changes only on an edge of its own clock, and only when that domain's enable is high.

The raw XOR output is asynchronous to both clocks. The block therefore also gives each domain its own copy of the bit, passed through a chain of synchroniser flops clocked in that domain. A typical use is an event detector or a request flag. The producer raises the bit. The consumer watches its synchronised copy, does its work, and then lowers the bit. The producer watches its own synchronised copy to learn when it may raise the bit again. Keeping raises and lowers strictly alternating is the job of the logic that drives the enables.

Top module: `xdom_flag`

## Requirements
- R1: While both resets are held low, flag_raw, flag_set_sync and flag_clr_sync all read 0. Each reset is synchronous and active-low, and it acts on an edge of its own domain's clock.
- R2: An edge of set_clk with set_en high, taken while the flag is low, makes flag_raw read 1 immediately after that edge.
- R3: An edge of clr_clk with clr_en high, taken while the flag is high, makes flag_raw read 0 immediately after that edge.
- R4: Edges of set_clk taken while set_en is low leave flag_raw unchanged.
- R5: Edges of clr_clk taken while clr_en is low leave flag_raw unchanged.
- R6: Repeating an operation without the opposite one in between has no effect. A second enabled set edge while the flag is high leaves it high, and a second enabled clear edge while the flag is low leaves it low.
- R7: flag_set_sync follows flag_raw through SYNC_STAGES set_clk flops (default 2). After an enabled set edge k, it still reads 0 after edge k+1 and reads 1 after edge k+2.
- R8: flag_clr_sync follows flag_raw through SYNC_STAGES clr_clk flops, so a change of the flag reaches it two clr_clk edges after the change (default 2).
- R9: Asserting both resets in the middle of operation, with the flag and both synchronised copies high, returns all three outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| set_clk | input | 1 | Clock of the raising domain |
| set_rst_n | input | 1 | Synchronous active-low reset, raising domain |
| set_en | input | 1 | Enable for the raise operation |
| clr_clk | input | 1 | Clock of the lowering domain |
| clr_rst_n | input | 1 | Synchronous active-low reset, lowering domain |
| clr_en | input | 1 | Enable for the lower operation |
| flag_raw | output | 1 | Unsynchronised XOR of the two ring flops |
| flag_set_sync | output | 1 | Flag synchronised to set_clk |
| flag_clr_sync | output | 1 | Flag synchronised to clr_clk |

## Verification
On every edge of its own clock, the checker confirms four things. An enabled raise loads the complement of the lowering flop. An enabled lower copies the raising flop. A disabled edge holds its flop. Each synchronised copy lags the raw flag by exactly the stage count. The absolute value of the flag, the no-effect case of a repeated raise or lower, and recovery from reset in the middle of operation depend on the order of events across both domains. Only the bench's sequenced scenarios can show those, and the bench runs them on two clocks whose edges never coincide.

// File: rtl/xdom_flag_pkg.sv
// Package: shared constants for the dual-clock flag.
// Assumes: nothing; holds only compile-time values.
package xdom_flag_pkg;
    // Smallest synchroniser depth the block accepts.
    localparam int unsigned MIN_SYNC_STAGES = 2;
    // Reset value of each ring flop, which makes the flag read 0 after reset.
    localparam logic RING_RESET_VAL = 1'b0;
endpackage

// File: rtl/xdom_ring_cell.sv
// Module: one flop of the twisted ring.
// When en is high on a clock edge, the flop loads the partner flop's output,
// inverted when INVERT is 1 (raising side) and as is when INVERT is 0
// (lowering side).
// Assumes: the partner output does not change near this clock's edge while en is
// high. The caller's alternation protocol guarantees this.
module xdom_ring_cell #(
    parameter bit INVERT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic partner_q,
    output logic q
);
    import xdom_flag_pkg::*;

    logic next_d;

    // Choose the value loaded from the partner: inverted or copied.
    generate
        if (INVERT) begin : g_inv
            always_comb next_d = ~partner_q;
        end else begin : g_copy
            always_comb next_d = partner_q;
        end
    endgenerate

    // Ring flop with synchronous active-low reset and a load enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RING_RESET_VAL;
        else if (en)
            q <= next_d;
    end
endmodule

// File: rtl/xdom_sync.sv
// Module: multi-flop synchroniser for one bit.
// The output follows the input after STAGES clock edges.
// Assumes: STAGES >= 2. The input may change at any time relative to clk.
module xdom_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input along the chain. The synchronous reset clears every stage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain <= '0;
        else
            chain <= {chain[STAGES-2:0], d};
    end

    // The last stage is the synchronised output.
    always_comb q = chain[STAGES-1];
endmodule

// File: rtl/xdom_flag.sv
// Module: status flag raised from one clock domain and lowered from another.
// Two ring flops, one per domain, are XORed to form the flag. Each domain gets
// its own synchronised copy of the flag.
// Assumes: raises and lowers strictly alternate, and each side waits for its
// synchronised copy before acting again. This block does not enforce that.
module xdom_flag #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic set_clk,
    input  logic set_rst_n,
    input  logic set_en,
    input  logic clr_clk,
    input  logic clr_rst_n,
    input  logic clr_en,
    output logic flag_raw,
    output logic flag_set_sync,
    output logic flag_clr_sync
);
    import xdom_flag_pkg::*;

    localparam int unsigned DEPTH =
        (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

    logic set_q;
    logic clr_q;

    // Raising flop: loads the complement of the lowering flop.
    xdom_ring_cell #(.INVERT(1'b1)) u_set_cell (
        .clk       (set_clk),
        .rst_n     (set_rst_n),
        .en        (set_en),
        .partner_q (clr_q),
        .q         (set_q)
    );

    // Lowering flop: loads a copy of the raising flop.
    xdom_ring_cell #(.INVERT(1'b0)) u_clr_cell (
        .clk       (clr_clk),
        .rst_n     (clr_rst_n),
        .en        (clr_en),
        .partner_q (set_q),
        .q         (clr_q)
    );

    // The flag is high while the two ring flops differ.
    always_comb flag_raw = set_q ^ clr_q;

    // Copy of the flag synchronised to the raising domain.
    xdom_sync #(.STAGES(DEPTH)) u_sync_set (
        .clk   (set_clk),
        .rst_n (set_rst_n),
        .d     (flag_raw),
        .q     (flag_set_sync)
    );

    // Copy of the flag synchronised to the lowering domain.
    xdom_sync #(.STAGES(DEPTH)) u_sync_clr (
        .clk   (clr_clk),
        .rst_n (clr_rst_n),
        .d     (flag_raw),
        .q     (flag_clr_sync)
    );
endmodule

// File: rtl/xdom_flag_chk.sv
// Module: property checker for xdom_flag, attached by bind.
// Assumes: the caller respects raise/lower alternation, so the partner flop is
// steady across any enabled edge.
module xdom_flag_chk #(
    parameter int unsigned STAGES = 2
) (
    input logic set_clk,
    input logic set_rst_n,
    input logic set_en,
    input logic clr_clk,
    input logic clr_rst_n,
    input logic clr_en,
    input logic set_q,
    input logic clr_q,
    input logic flag_raw,
    input logic flag_set_sync,
    input logic flag_clr_sync
);
    logic [1:0] set_age;
    logic [1:0] clr_age;

    // Count raising-domain cycles since reset, saturating at 3.
    always_ff @(posedge set_clk) begin
        if (!set_rst_n)
            set_age <= 2'd0;
        else if (set_age != 2'd3)
            set_age <= set_age + 2'd1;
    end

    // Count lowering-domain cycles since reset, saturating at 3.
    always_ff @(posedge clr_clk) begin
        if (!clr_rst_n)
            clr_age <= 2'd0;
        else if (clr_age != 2'd3)
            clr_age <= clr_age + 2'd1;
    end

    // R2
    set_loads_inverse_chk: assert property (@(posedge set_clk) disable iff (!set_rst_n)
        set_en |=> (set_q == ~$past(clr_q)));

    // R3
    clr_copies_set_chk: assert property (@(posedge clr_clk) disable iff (!clr_rst_n)
        clr_en |=> (clr_q == $past(set_q)));

    // R4
    set_hold_chk: assert property (@(posedge set_clk) disable iff (!set_rst_n)
        !set_en |=> $stable(set_q));

    // R5
    clr_hold_chk: assert property (@(posedge clr_clk) disable iff (!clr_rst_n)
        !clr_en |=> $stable(clr_q));

    generate
        if (STAGES == 2) begin : g_lag
            // R7
            sync_set_lag_chk: assert property (@(posedge set_clk) disable iff (!set_rst_n)
                (set_age >= 2'd2) |-> (flag_set_sync == $past(flag_raw, 2)));

            // R8
            sync_clr_lag_chk: assert property (@(posedge clr_clk) disable iff (!clr_rst_n)
                (clr_age >= 2'd2) |-> (flag_clr_sync == $past(flag_raw, 2)));
        end
    endgenerate
endmodule

bind xdom_flag xdom_flag_chk #(.STAGES(DEPTH)) u_chk (
    .set_clk       (set_clk),
    .set_rst_n     (set_rst_n),
    .set_en        (set_en),
    .clr_clk       (clr_clk),
    .clr_rst_n     (clr_rst_n),
    .clr_en        (clr_en),
    .set_q         (set_q),
    .clr_q         (clr_q),
    .flag_raw      (flag_raw),
    .flag_set_sync (flag_set_sync),
    .flag_clr_sync (flag_clr_sync)
);

// File: tb/sim_xdom_flag.sv
// Bench: the driver tasks push expected items into a queue, and a monitor pops and
// compares them 2 ns after each set_clk rising edge.
// set_clk runs at 125 MHz (rising edges at 4+8k ns). clr_clk has a 10 ns period
// with rising edges at 3+10m ns, so edges of the two clocks never coincide.
module sim_xdom_flag;
    typedef enum logic [1:0] {K_RAW, K_SSYNC, K_CSYNC} kind_t;
    typedef struct {
        kind_t kind;
        logic  exp;
        string req;
    } item_t;

    logic set_clk = 1'b0;
    logic clr_clk = 1'b0;
    logic set_rst_n = 1'b0;
    logic clr_rst_n = 1'b0;
    logic set_en = 1'b0;
    logic clr_en = 1'b0;
    logic flag_raw, flag_set_sync, flag_clr_sync;

    item_t exp_q[$];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    xdom_flag u0 (
        .set_clk(set_clk), .set_rst_n(set_rst_n), .set_en(set_en),
        .clr_clk(clr_clk), .clr_rst_n(clr_rst_n), .clr_en(clr_en),
        .flag_raw(flag_raw), .flag_set_sync(flag_set_sync), .flag_clr_sync(flag_clr_sync)
    );

    always #4 set_clk = ~set_clk;

    initial begin
        #3;
        forever begin
            clr_clk = 1'b1; #5;
            clr_clk = 1'b0; #5;
        end
    end

    task automatic push(input kind_t k, input logic e, input string r);
        item_t it;
        it.kind = k; it.exp = e; it.req = r;
        exp_q.push_back(it);
    endtask

    // Monitor: compare every queued item with the outputs, 2 ns after the edge.
    initial begin
        forever begin
            @(posedge set_clk);
            #2;
            while (exp_q.size() > 0) begin
                item_t it;
                logic act;
                it = exp_q.pop_front();
                case (it.kind)
                    K_RAW:   act = flag_raw;
                    K_SSYNC: act = flag_set_sync;
                    default: act = flag_clr_sync;
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%b expected=%b", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    // One enabled set edge. Returns at the falling edge after it.
    task automatic do_set();
        @(negedge set_clk); set_en = 1'b1;
        @(negedge set_clk); set_en = 1'b0;
    endtask

    // One enabled clear edge. Returns at the falling edge after it.
    task automatic do_clr();
        @(negedge clr_clk); clr_en = 1'b1;
        @(negedge clr_clk); clr_en = 1'b0;
    endtask

    task automatic set_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge set_clk);
    endtask

    task automatic clr_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge clr_clk);
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge set_clk);
        set_wait(1);
    endtask

    // Watchdog: a hung run counts as one failed check and still prints the summary.
    initial begin
        #200000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        set_wait(4);
        push(K_RAW, 1'b0, "R1"); push(K_SSYNC, 1'b0, "R1"); push(K_CSYNC, 1'b0, "R1");
        drain();
        @(negedge set_clk); set_rst_n = 1'b1; clr_rst_n = 1'b1;
        set_wait(4);

        // R4: set_clk edges with set_en low leave the flag low.
        set_wait(5);
        push(K_RAW, 1'b0, "R4");
        drain();

        // R2 and R7: raise the flag, then check the sync lag cycle by cycle.
        do_set();
        push(K_RAW, 1'b1, "R2"); push(K_SSYNC, 1'b0, "R7");
        @(negedge set_clk);
        push(K_SSYNC, 1'b1, "R7");
        drain();
        // R8: the lowering domain sees the flag after its own stages.
        clr_wait(3);
        push(K_CSYNC, 1'b1, "R8");
        drain();

        // R6: a repeated raise keeps the flag high.
        do_set();
        push(K_RAW, 1'b1, "R6");
        drain();

        // R5: clr_clk edges with clr_en low leave the flag high.
        clr_wait(5);
        push(K_RAW, 1'b1, "R5");
        drain();

        // R3 and R8: lower the flag.
        do_clr();
        push(K_RAW, 1'b0, "R3");
        drain();
        clr_wait(3);
        push(K_CSYNC, 1'b0, "R8"); push(K_SSYNC, 1'b0, "R7");
        drain();

        // R6: a repeated lower keeps the flag low.
        do_clr();
        push(K_RAW, 1'b0, "R6");
        drain();

        // Several alternating raise and lower cycles.
        for (int c = 0; c < 3; c++) begin
            do_set();
            push(K_RAW, 1'b1, "R2");
            drain(); clr_wait(3);
            do_clr();
            push(K_RAW, 1'b0, "R3");
            drain(); clr_wait(3); set_wait(3);
        end

        // R9: reset in the middle of operation with everything high.
        do_set(); set_wait(3); clr_wait(3);
        push(K_RAW, 1'b1, "R9"); push(K_SSYNC, 1'b1, "R9"); push(K_CSYNC, 1'b1, "R9");
        drain();
        @(negedge set_clk); set_rst_n = 1'b0; clr_rst_n = 1'b0;
        set_wait(3); clr_wait(3);
        push(K_RAW, 1'b0, "R9"); push(K_SSYNC, 1'b0, "R9"); push(K_CSYNC, 1'b0, "R9");
        drain();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule